// File: doc/BRIEF.md
# Code Memory Program and Verify Controller

This block is the on-chip control that lets an external programmer write, read back and lock a microcontroller's 4K-byte non-volatile code memory. The programmer sets the level of the device reset pin, the program strobe pin and the top two lines of the high port. The decoder turns those levels into one of four service modes: program, inhibit, verify or security-set. The 12-bit address is made of the full low port (bits 7:0) and lines 3:0 of the high port (bits 11:8). Code bytes go in on `data_in` and come out on `data_out` with `data_oe`.

A write takes place only at the end of a program pulse on the active-low latch pin. The pulse width must lie inside a millisecond window, scaled to clock cycles by a parameter, and the high-voltage supply must be present for the whole pulse. A write can only clear bits. A sticky security bit, set by a security-set pulse, blocks readout, further programming and external code execution. Only a full erase clears it. The erase sweeps the whole array to all ones and runs in the background.

The array is a behavioural register file. The high-voltage supply reaches the block only as a logic "present" flag.

Top module: `codemem_prog_ctrl`

## Requirements
- R1: With `pin_rst`=1 and `strobe_n`=0, `mode` shows the decoded mode one cycle after the pins settle. The select lines are `hi_port[7:6]`. Value 00 gives verify (code 3). Value 10 gives program (code 1) when `hv_present`=1, and inhibit (code 2) otherwise. Value 11 gives security-set (code 4). Every other combination, including `pin_rst`=0 or `strobe_n`=1, gives idle (code 0).
- R2: A low pulse on `latch_n` in program mode writes the byte when it lasts between MIN and MAX sampled cycles inclusive. By default MIN is 90 and MAX is 110 (45 and 55 ms at 2 cycles per ms). The stored byte becomes the old byte AND the new byte. `prog_err` reads 0 within 3 cycles of `latch_n` rising.
- R3: A pulse shorter than MIN or longer than MAX writes nothing, and `prog_err` reads 1 within 3 cycles of `latch_n` rising.
- R4: A pulse that starts without `hv_present`, which is the inhibit case, writes nothing and sets `prog_err`. So does a pulse during which `hv_present` drops.
- R5: The address and data are captured on the first low cycle of the pulse. Later changes to them during the pulse have no effect on the write.
- R6: In verify mode, `data_oe` rises only after the address has been stable for VFY_DLY cycles (48 by default). `data_out` then carries the stored byte. An address change restarts the wait, and `data_out` reads 0 while `data_oe`=0.
- R7: A security-set pulse that is valid in width and has high voltage sets `sec_locked` within 3 cycles of `latch_n` rising. Without high voltage it leaves `sec_locked` unchanged and sets `prog_err`.
- R8: While `sec_locked`=1, verify never raises `data_oe`, a program pulse writes nothing and sets `prog_err`, and `ext_fetch_ok` stays 0 whatever `ext_fetch_req` is.
- R9: An `erase_req` pulse holds `erase_busy` high for 4096 cycles while every byte is set to 0xFF, and then clears `sec_locked`. Program pulses that end during the erase set `prog_err` and write nothing.
- R10: `prog_err` stays set until the next pulse starts. It then reads 0 while that pulse is still low.
- R11: After `rst_n` is held low, `mode` is 0, and `data_oe`, `prog_err` and `erase_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low controller reset |
| pin_rst | input | 1 | Device reset pin level, high during service modes |
| strobe_n | input | 1 | Program strobe pin level, low during service modes |
| latch_n | input | 1 | Active-low program pulse pin |
| hv_present | input | 1 | Supply pin is at programming voltage |
| lo_port | input | 8 | Address bits 7:0 |
| hi_port | input | 8 | Bits 3:0 are address 11:8, bits 7:6 select the mode |
| data_in | input | 8 | Code byte to program |
| data_out | output | 8 | Code byte read out in verify |
| data_oe | output | 1 | `data_out` is valid and driven |
| erase_req | input | 1 | Pulse that starts a full erase |
| ext_fetch_req | input | 1 | Core asks to fetch from external code memory |
| ext_fetch_ok | output | 1 | External fetch granted |
| mode | output | 3 | Decoded service mode code |
| prog_err | output | 1 | Last pulse was aborted or refused |
| sec_locked | output | 1 | Security bit state |
| erase_busy | output | 1 | Erase sweep in progress |

## Verification
A wrong pulse counter or captured kind shows at `prog_err` and `sec_locked` within three cycles of the pulse ending. It also shows at the next verify of the target address, one verify wait later. A corrupted array byte or a missing AND with the old byte shows only when that address is read back, so the bench reads back every address it writes and its neighbours. A stuck security bit shows at once on `ext_fetch_ok`. An erase sweep that stops short shows at the top address after the sweep.

// File: rtl/cmp_pkg.sv
// Shared types for the code memory programming controller.
package cmp_pkg;
    // Service mode codes, visible on the mode output port.
    typedef enum logic [2:0] {
        MODE_IDLE    = 3'd0,
        MODE_PROGRAM = 3'd1,
        MODE_INHIBIT = 3'd2,
        MODE_VERIFY  = 3'd3,
        MODE_SECURE  = 3'd4
    } pgm_mode_e;
endpackage

// File: rtl/cmp_mode_decode.sv
// Decodes pin strapping into a service mode.
// Assumes the pins are already synchronous to clk. mode_c is combinational,
// and mode_q is the same value one cycle later.
module cmp_mode_decode
    import cmp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin_rst,
    input  logic      strobe_n,
    input  logic      hv_present,
    input  logic [1:0] sel,
    output pgm_mode_e mode_c,
    output pgm_mode_e mode_q
);
    // Pin levels to mode
    always_comb begin
        mode_c = MODE_IDLE;
        if (pin_rst && !strobe_n) begin
            unique case (sel)
                2'b00:   mode_c = MODE_VERIFY;
                2'b10:   mode_c = hv_present ? MODE_PROGRAM : MODE_INHIBIT;
                2'b11:   mode_c = MODE_SECURE;
                default: mode_c = MODE_IDLE;
            endcase
        end
    end

    // Registered copy for the mode port
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_IDLE;
        else        mode_q <= mode_c;
    end
endmodule

// File: rtl/cmp_pulse_timer.sv
// Measures program pulses on the active-low latch pin.
// A pulse starts only in program, inhibit or secure mode. It captures the
// address, data and kind on its first low cycle and counts the low cycles.
// When the pin rises it emits one ok or bad strobe. A pulse is bad if its
// width is outside the window, if high voltage was missing at any low
// cycle, or if the mode group changed during the pulse.
module cmp_pulse_timer
    import cmp_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    parameter int MIN_CNT = 90,
    parameter int MAX_CNT = 110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_n,
    input  logic              hv_present,
    input  pgm_mode_e         mode_c,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              start_stb,
    output logic              ok_stb,
    output logic              bad_stb,
    output logic              sec_q,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);
    localparam int CNT_W = $clog2(MAX_CNT + 2);
    localparam logic [CNT_W-1:0] MIN_C = CNT_W'(MIN_CNT);
    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_CNT);

    logic             lat_q;
    logic             active;
    logic [CNT_W-1:0] cnt;
    logic             hv_ok;
    logic             grp_ok;
    logic             grp_c;
    logic             sec_c;

    assign grp_c = (mode_c == MODE_PROGRAM) || (mode_c == MODE_INHIBIT) ||
                   (mode_c == MODE_SECURE);
    assign sec_c = (mode_c == MODE_SECURE);

    // Pulse tracking, width counting and outcome strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q     <= 1'b1;
            active    <= 1'b0;
            cnt       <= '0;
            hv_ok     <= 1'b0;
            grp_ok    <= 1'b0;
            sec_q     <= 1'b0;
            cap_addr  <= '0;
            cap_data  <= '0;
            start_stb <= 1'b0;
            ok_stb    <= 1'b0;
            bad_stb   <= 1'b0;
        end else begin
            lat_q     <= latch_n;
            start_stb <= 1'b0;
            ok_stb    <= 1'b0;
            bad_stb   <= 1'b0;
            if (!active) begin
                if (lat_q && !latch_n && grp_c) begin
                    active    <= 1'b1;
                    cnt       <= CNT_W'(1);
                    hv_ok     <= hv_present;
                    grp_ok    <= 1'b1;
                    sec_q     <= sec_c;
                    cap_addr  <= addr;
                    cap_data  <= data;
                    start_stb <= 1'b1;
                end
            end else if (!latch_n) begin
                if (cnt <= MAX_C) cnt <= cnt + 1'b1;
                hv_ok <= hv_ok & hv_present;
                if (!grp_c || (sec_c != sec_q)) grp_ok <= 1'b0;
            end else begin
                active <= 1'b0;
                if ((cnt >= MIN_C) && (cnt <= MAX_C) && hv_ok && grp_ok)
                    ok_stb <= 1'b1;
                else
                    bad_stb <= 1'b1;
            end
        end
    end

    // An outcome is reported only after the pin has been seen high
    AST_OUTCOME_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (ok_stb || bad_stb) |-> $past(latch_n));  // R2
endmodule

// File: rtl/cmp_code_array.sv
// Behavioural code memory with an AND-only write port, a registered read
// and a background erase that sweeps one byte per cycle to all ones.
// The contents are non-volatile: rst_n does not touch them.
module cmp_code_array #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              erase_req,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              erase_busy,
    output logic              erase_done
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] ptr;

    // Erase sequencer: start, advance, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            erase_busy <= 1'b0;
            erase_done <= 1'b0;
            ptr        <= '0;
        end else begin
            erase_done <= 1'b0;
            if (!erase_busy) begin
                if (erase_req) begin
                    erase_busy <= 1'b1;
                    ptr        <= '0;
                end
            end else begin
                ptr <= ptr + 1'b1;
                if (ptr == LAST) begin
                    erase_busy <= 1'b0;
                    erase_done <= 1'b1;
                end
            end
        end
    end

    // Array update: an erase write, or a program that can only clear bits
    always_ff @(posedge clk) begin
        if (erase_busy)  mem[ptr]     <= '1;
        else if (wr_en)  mem[wr_addr] <= mem[wr_addr] & wr_data;
    end

    // Registered read for verify
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_addr];
    end

    AST_DONE_AFTER_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        erase_done |-> $past(erase_busy));  // R9
endmodule

// File: rtl/codemem_prog_ctrl.sv
// Top of the code memory program and verify controller.
// Combines the mode decoder, pulse timer and array, and owns the security
// bit, the error flag and the verify wait. The security bit is
// non-volatile: only an erase clears it, and rst_n does not.
module codemem_prog_ctrl
    import cmp_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 8,
    parameter int TICKS_PER_MS = 2,
    parameter int PULSE_MIN_MS = 45,
    parameter int PULSE_MAX_MS = 55,
    parameter int VFY_DLY      = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_rst,
    input  logic              strobe_n,
    input  logic              latch_n,
    input  logic              hv_present,
    input  logic [7:0]        lo_port,
    input  logic [7:0]        hi_port,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    input  logic              erase_req,
    input  logic              ext_fetch_req,
    output logic              ext_fetch_ok,
    output logic [2:0]        mode,
    output logic              prog_err,
    output logic              sec_locked,
    output logic              erase_busy
);
    localparam int MIN_CNT = PULSE_MIN_MS * TICKS_PER_MS;
    localparam int MAX_CNT = PULSE_MAX_MS * TICKS_PER_MS;
    localparam int HI_AW   = ADDR_W - 8;
    localparam int VC_W    = $clog2(VFY_DLY + 1);
    localparam logic [VC_W-1:0] VC_TOP = VC_W'(VFY_DLY);

    pgm_mode_e         mode_c, mode_q;
    logic [ADDR_W-1:0] addr_c, addr_q, cap_addr;
    logic [DATA_W-1:0] cap_data, rd_data;
    logic              start_stb, ok_stb, bad_stb, sec_q;
    logic              erase_done, refuse, wr_en, set_lock;
    logic [VC_W-1:0]   vcnt;

    assign addr_c = {hi_port[HI_AW-1:0], lo_port};

    cmp_mode_decode u_dec (
        .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .strobe_n(strobe_n),
        .hv_present(hv_present), .sel(hi_port[7:6]),
        .mode_c(mode_c), .mode_q(mode_q)
    );

    cmp_pulse_timer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_CNT(MIN_CNT), .MAX_CNT(MAX_CNT)
    ) u_pulse (
        .clk(clk), .rst_n(rst_n), .latch_n(latch_n), .hv_present(hv_present),
        .mode_c(mode_c), .addr(addr_c), .data(data_in),
        .start_stb(start_stb), .ok_stb(ok_stb), .bad_stb(bad_stb),
        .sec_q(sec_q), .cap_addr(cap_addr), .cap_data(cap_data)
    );

    cmp_code_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .erase_req(erase_req),
        .wr_en(wr_en), .wr_addr(cap_addr), .wr_data(cap_data),
        .rd_addr(addr_c), .rd_data(rd_data),
        .erase_busy(erase_busy), .erase_done(erase_done)
    );

    // Commit gating: an erase in progress or the lock refuses a write
    assign refuse   = erase_busy || (!sec_q && sec_locked);
    assign wr_en    = ok_stb && !sec_q && !refuse;
    assign set_lock = ok_stb && sec_q && !erase_busy;

    // Security bit: set by a valid secure pulse, cleared only by erase
    always_ff @(posedge clk) begin
        if (erase_done)    sec_locked <= 1'b0;
        else if (set_lock) sec_locked <= 1'b1;
    end

    // Error flag: cleared when a pulse starts, set on abort or refusal
    always_ff @(posedge clk) begin
        if (!rst_n)                        prog_err <= 1'b0;
        else if (start_stb)                prog_err <= 1'b0;
        else if (bad_stb || (ok_stb && refuse)) prog_err <= 1'b1;
    end

    // Verify wait: counts cycles of stable address in verify mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            vcnt   <= '0;
        end else begin
            addr_q <= addr_c;
            if ((mode_c == MODE_VERIFY) && (addr_c == addr_q))
                vcnt <= (vcnt == VC_TOP) ? vcnt : vcnt + 1'b1;
            else
                vcnt <= '0;
        end
    end

    assign data_oe      = (vcnt == VC_TOP) && !sec_locked && !erase_busy;
    assign data_out     = data_oe ? rd_data : '0;
    assign ext_fetch_ok = ext_fetch_req && !sec_locked;
    assign mode         = mode_q;

    AST_OE_ONLY_VERIFY: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> (mode_q == MODE_VERIFY));  // R6
    AST_LOCK_FROM_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_locked) |-> $past(ok_stb && sec_q));  // R7
    AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(erase_busy) |=> !sec_locked);  // R9
    AST_ERR_CLEARS_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !prog_err);  // R10
endmodule

// File: tb/codemem_prog_ctrl_bench.sv
module codemem_prog_ctrl_bench;
    localparam int DEPTH = 4096;
    localparam int VFY   = 48;

    logic       clk = 1'b0;
    logic       rst_n, pin_rst, strobe_n, latch_n, hv_present;
    logic [7:0] lo_port, hi_port, data_in, data_out;
    logic       data_oe, erase_req, ext_fetch_req, ext_fetch_ok;
    logic [2:0] mode;
    logic       prog_err, sec_locked, erase_busy;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    codemem_prog_ctrl u_codemem_prog_ctrl (
        .clk(clk), .rst_n(rst_n), .pin_rst(pin_rst), .strobe_n(strobe_n),
        .latch_n(latch_n), .hv_present(hv_present), .lo_port(lo_port),
        .hi_port(hi_port), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .erase_req(erase_req), .ext_fetch_req(ext_fetch_req),
        .ext_fetch_ok(ext_fetch_ok), .mode(mode), .prog_err(prog_err),
        .sec_locked(sec_locked), .erase_busy(erase_busy)
    );

    // {addr[11:0], data[7:0], width[7:0], exp_err, exp_byte[7:0]}
    localparam logic [36:0] VEC [0:6] = '{
        {12'h001, 8'hA5, 8'd100, 1'b0, 8'hA5},
        {12'h001, 8'h3C, 8'd100, 1'b0, 8'h24},
        {12'h002, 8'h00, 8'd89,  1'b1, 8'hFF},
        {12'h003, 8'h0F, 8'd111, 1'b1, 8'hFF},
        {12'h004, 8'h5A, 8'd90,  1'b0, 8'h5A},
        {12'hFFF, 8'h81, 8'd110, 1'b0, 8'h81},
        {12'h800, 8'h7E, 8'd100, 1'b0, 8'h7E}
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Drive one pulse; drop_at/swap_at/clr_at act at that low cycle (0 = never)
    task automatic pulse(input logic sec, input logic [11:0] a, input logic [7:0] d,
                         input int width, input logic hv, input int drop_at,
                         input int swap_at, input int clr_at);
        pin_rst = 1'b1; strobe_n = 1'b0; hv_present = hv;
        hi_port = {sec ? 2'b11 : 2'b10, 2'b00, a[11:8]};
        lo_port = a[7:0]; data_in = d; latch_n = 1'b1;
        cyc(3);
        latch_n = 1'b0;
        for (int i = 1; i <= width; i++) begin
            @(negedge clk);
            if (i == drop_at) hv_present = 1'b0;
            if (i == swap_at) begin
                lo_port = a[7:0] + 8'd1; data_in = ~d;
            end
            if (i == clr_at) chk(prog_err == 1'b0, "R10 err cleared at pulse start", prog_err, 0);
        end
        latch_n = 1'b1;
        cyc(4);
        hv_present = 1'b0;
    endtask

    task automatic vfy(input logic [11:0] a, input logic exp_oe, input logic [7:0] exp,
                       input string tag);
        pin_rst = 1'b1; strobe_n = 1'b0; hv_present = 1'b0; latch_n = 1'b1;
        hi_port = {4'b0000, a[11:8]}; lo_port = a[7:0];
        cyc(VFY + 6);
        chk(data_oe == exp_oe, tag, data_oe, exp_oe);
        if (exp_oe) chk(data_out == exp, tag, data_out, exp);
    endtask

    task automatic mode_chk(input logic pr, input logic sn, input logic [1:0] sel,
                            input logic hv, input logic [2:0] exp);
        pin_rst = pr; strobe_n = sn; hi_port = {sel, 6'd0}; hv_present = hv;
        cyc(2);
        chk(mode == exp, "R1 mode decode", mode, exp);
    endtask

    task automatic do_erase();
        erase_req = 1'b1; cyc(1); erase_req = 1'b0;
        cyc(1);
        chk(erase_busy == 1'b1, "R9 erase busy", erase_busy, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; pin_rst = 1'b0; strobe_n = 1'b1; latch_n = 1'b1;
        hv_present = 1'b0; lo_port = '0; hi_port = '0; data_in = '0;
        erase_req = 1'b0; ext_fetch_req = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R11 reset state
        chk(mode == 3'd0, "R11 mode after reset", mode, 0);
        chk(data_oe == 1'b0, "R11 oe after reset", data_oe, 0);
        chk(prog_err == 1'b0, "R11 err after reset", prog_err, 0);
        chk(erase_busy == 1'b0, "R11 busy after reset", erase_busy, 0);

        // R9 initial erase brings array blank and unlocked
        do_erase();
        cyc(DEPTH + 4);
        chk(erase_busy == 1'b0, "R9 erase ends", erase_busy, 0);
        chk(sec_locked == 1'b0, "R9 unlocked after erase", sec_locked, 0);
        ext_fetch_req = 1'b1; cyc(1);
        chk(ext_fetch_ok == 1'b1, "R8 fetch allowed unlocked", ext_fetch_ok, 1);

        // R1 mode decode
        mode_chk(1, 0, 2'b00, 0, 3'd3);
        mode_chk(1, 0, 2'b10, 1, 3'd1);
        mode_chk(1, 0, 2'b10, 0, 3'd2);
        mode_chk(1, 0, 2'b11, 1, 3'd4);
        mode_chk(1, 0, 2'b01, 1, 3'd0);
        mode_chk(0, 0, 2'b10, 1, 3'd0);
        mode_chk(1, 1, 2'b00, 0, 3'd0);

        // R2 and R3 vector walk
        for (int k = 0; k < 7; k++) begin
            pulse(1'b0, VEC[k][36:25], VEC[k][24:17], int'(VEC[k][16:9]), 1'b1, 0, 0, 0);
            chk(prog_err == VEC[k][8], VEC[k][8] ? "R3 bad width err" : "R2 write err",
                prog_err, VEC[k][8]);
            vfy(VEC[k][36:25], 1'b1, VEC[k][7:0], "R2 R3 readback");
        end

        // R4 inhibit (no high voltage) and mid-pulse drop
        pulse(1'b0, 12'h020, 8'h00, 100, 1'b0, 0, 0, 0);
        chk(prog_err == 1'b1, "R4 inhibit pulse err", prog_err, 1);
        vfy(12'h020, 1'b1, 8'hFF, "R4 inhibit no write");
        pulse(1'b0, 12'h021, 8'h00, 100, 1'b1, 50, 0, 0);
        chk(prog_err == 1'b1, "R4 hv drop err", prog_err, 1);
        vfy(12'h021, 1'b1, 8'hFF, "R4 hv drop no write");

        // R10 error clears at the next pulse start; R5 capture at start
        pulse(1'b0, 12'h030, 8'h11, 100, 1'b1, 0, 20, 5);
        chk(prog_err == 1'b0, "R5 good pulse err", prog_err, 0);
        vfy(12'h030, 1'b1, 8'h11, "R5 captured data");
        vfy(12'h031, 1'b1, 8'hFF, "R5 later address ignored");

        // R6 verify wait and restart on address change
        pin_rst = 1'b1; strobe_n = 1'b0; hi_port = 8'h00; lo_port = 8'h01;
        cyc(10);
        chk(data_oe == 1'b0, "R6 oe waits", data_oe, 0);
        chk(data_out == 8'h00, "R6 data zero while not valid", data_out, 0);
        cyc(30);
        lo_port = 8'h04;
        cyc(20);
        chk(data_oe == 1'b0, "R6 address change restarts", data_oe, 0);
        cyc(40);
        chk(data_oe == 1'b1, "R6 oe after wait", data_oe, 1);
        chk(data_out == 8'h5A, "R6 data after restart", data_out, 8'h5A);

        // R7 security set without then with high voltage
        pulse(1'b1, 12'h010, 8'h00, 100, 1'b0, 0, 0, 0);
        chk(sec_locked == 1'b0, "R7 no lock without hv", sec_locked, 0);
        chk(prog_err == 1'b1, "R7 err without hv", prog_err, 1);
        pulse(1'b1, 12'h010, 8'h00, 100, 1'b1, 0, 0, 0);
        chk(sec_locked == 1'b1, "R7 lock set", sec_locked, 1);

        // R8 locked behaviour
        vfy(12'h001, 1'b0, 8'h00, "R8 verify refused");
        chk(ext_fetch_ok == 1'b0, "R8 fetch blocked", ext_fetch_ok, 0);
        pulse(1'b0, 12'h040, 8'h00, 100, 1'b1, 0, 0, 0);
        chk(prog_err == 1'b1, "R8 program refused", prog_err, 1);

        // R9 erase: program during sweep refused, then blank and unlocked
        do_erase();
        pulse(1'b0, 12'h041, 8'h00, 100, 1'b1, 0, 0, 0);
        chk(prog_err == 1'b1, "R9 program during erase refused", prog_err, 1);
        cyc(DEPTH);
        chk(sec_locked == 1'b0, "R9 erase clears lock", sec_locked, 0);
        chk(ext_fetch_ok == 1'b1, "R9 fetch restored", ext_fetch_ok, 1);
        vfy(12'h001, 1'b1, 8'hFF, "R9 byte blank");
        vfy(12'hFFF, 1'b1, 8'hFF, "R9 top byte blank");
        vfy(12'h040, 1'b1, 8'hFF, "R8 refused write left blank");

        finish_run();
    end
endmodule